// File: doc/BRIEF.md
# I2C Debug Bus Access Bridge

This block is a debug-port slave that sits behind a byte-level I2C transaction engine and turns short command transfers into cycles on an internal register bus. A debugger uses it for chip bring-up: it unlocks the port with a five-byte synchronisation string, then selects one of eight bus channels, stops or resumes the embedded MCU, and opens the register bus for reads and writes.

Each write transfer starts with one command byte. A bus-access command is followed by a big-endian address and optional write data. A read transfer that follows reads bytes from that address, and the address advances with every byte. In the 16-bit address mode, address 0x0000 is a local bank register that supplies bits 23..16 of every bus address. A channel selection of 0 picks the MCU external-data bus, 3 the power-domain register bus and 4 the main register bus.

The controller is one state machine with these states:
- OFF: locked.
- SYNC: collecting the unlock string.
- IDLE: unlocked, with no transfer open.
- CMD: waiting for the command byte.
- ADDR: shifting in address bytes.
- WDAT: taking write data.
- DRAIN: swallowing bytes after a non-bus command.
- RDAT: serving read bytes.

It moves between them as follows:
- A matching write start goes from OFF to SYNC. A matching read start leaves it in OFF.
- A stop in SYNC goes to IDLE if exactly the string arrived, and to OFF otherwise.
- In every unlocked state, a matching start goes to CMD when writing and to RDAT when reading.
- In CMD, the bus-access command goes to ADDR, the exit command goes to OFF, and every other byte goes to DRAIN.
- ADDR goes to WDAT after its last address byte.
- A stop, or a start for another device, takes any unlocked state to IDLE. In SYNC it returns to OFF instead.

Top module: `dbgx_bridge`

## Requirements
- R1: After reset the port is locked: chan=0, mcu_stop=0, no bus strobes. Every command is ignored until the bytes 0x53 0x45 0x52 0x44 0x42 arrive as the only bytes of one write transfer. A string split over two transfers leaves it locked.
- R2: Only a start whose 7-bit device address equals DEV_ADDR (default 0x59) is acknowledged (i2c_ack=1 in the start cycle) and processed. Other transfers get i2c_ack=0 and have no effect.
- R3: Command bytes 0x80..0x85 write one channel bit: bits [2:1] of the byte give the bit index and bit 0 gives its new value. No other command changes chan.
- R4: Command 0x37 sets mcu_stop to 1; command 0x36 clears it.
- R5: Command 0x35 enables bus access and 0x34 disables it. While disabled, no bus_wr or bus_rd occurs and every read byte is 0x00.
- R6: Command 0x10 followed by a 2-byte big-endian address (16-bit mode) makes each further byte of that transfer a bus_wr to that same address, with bus_wdata equal to the byte, in the cycle the byte arrives.
- R7: In a read transfer after a 0x10 address, each read request raises bus_rd in its cycle. i2c_rvalid with the data follows one cycle later, and the address increments by one per read byte.
- R8: In 16-bit mode a write to address 0x0000 loads the bank register with no bus cycle. bus_addr becomes {0x00, bank, addr16}, and reading 0x0000 returns the bank.
- R9: Command 0x45 is not acknowledged (i2c_ack=0), relocks the port and disables bus access. Channel and MCU-stop values are kept.
- R10: Unknown command bytes (for example 0x86, 0x99) are acknowledged and change nothing.
- R11: Bytes that follow a non-bus command in the same transfer are acknowledged and ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| i2c_start | input | 1 | Start or repeated start with address received |
| i2c_dev | input | 7 | Device address of the transfer |
| i2c_rnw | input | 1 | 1 for read transfer |
| i2c_wvalid | input | 1 | Write byte received |
| i2c_wbyte | input | 8 | Received byte |
| i2c_rreq | input | 1 | Master requests a read byte |
| i2c_stop | input | 1 | Stop condition |
| i2c_ack | output | 1 | Acknowledge for the current start or byte |
| i2c_rvalid | output | 1 | Read byte ready |
| i2c_rbyte | output | 8 | Read byte |
| bus_addr | output | 32 | Bus address |
| bus_wdata | output | 8 | Bus write data |
| bus_wr | output | 1 | Bus write strobe |
| bus_rd | output | 1 | Bus read strobe |
| bus_rdata | input | 8 | Bus read data, valid with bus_rd |
| chan | output | 3 | Bus channel selector |
| mcu_stop | output | 1 | MCU halt request |

## Verification
The unlock path is tried with three patterns: traffic before any unlock, the string split over two transfers, and the string sent whole. Only the last may open the port. Channel commands run from a table that sets and clears each bit in turn and includes an out-of-range code, which separates a correct bit index from a neighbouring one.

Bus accesses are tried disabled and enabled, at a plain address and at the bank address. The read tests compare two consecutive bytes, which exposes a missing address increment. Trailing bytes, an unknown command and the exit command show that ignored bytes really leave the outputs untouched.

// File: rtl/dbgx_pkg.sv
`timescale 1ns/1ps
package dbgx_pkg;

    typedef enum logic [2:0] {
        ST_OFF, ST_SYNC, ST_IDLE, ST_CMD, ST_ADDR, ST_WDAT, ST_DRAIN, ST_RDAT
    } st_t;

    typedef enum logic [2:0] {
        OP_NONE, OP_BUS, OP_BUS_ON, OP_BUS_OFF, OP_HALT, OP_RUN, OP_CHAN, OP_EXIT
    } op_t;

    localparam int SYNC_LEN = 5;

    function automatic logic [7:0] sync_byte(input logic [2:0] idx);
        case (idx)
            3'd0:    sync_byte = 8'h53;
            3'd1:    sync_byte = 8'h45;
            3'd2:    sync_byte = 8'h52;
            3'd3:    sync_byte = 8'h44;
            3'd4:    sync_byte = 8'h42;
            default: sync_byte = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/dbgx_cmd_dec.sv
`timescale 1ns/1ps
module dbgx_cmd_dec
    import dbgx_pkg::*;
(
    input  logic [7:0] code,
    output op_t        op,
    output logic [1:0] bit_sel,
    output logic       bit_val
);
    always_comb begin
        bit_sel = code[2:1];
        bit_val = code[0];
        case (code)
            8'h10:   op = OP_BUS;
            8'h35:   op = OP_BUS_ON;
            8'h34:   op = OP_BUS_OFF;
            8'h37:   op = OP_HALT;
            8'h36:   op = OP_RUN;
            8'h45:   op = OP_EXIT;
            8'h80, 8'h81, 8'h82, 8'h83, 8'h84, 8'h85: op = OP_CHAN;
            default: op = OP_NONE;
        endcase
    end
endmodule

// File: rtl/dbgx_addr_unit.sv
`timescale 1ns/1ps
module dbgx_addr_unit #(
    parameter bit WIDE = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        shift_en,
    input  logic [7:0]  shift_byte,
    input  logic        inc,
    input  logic        bank_we,
    input  logic [7:0]  bank_din,
    output logic [31:0] eff_addr,
    output logic        is_bank,
    output logic [7:0]  bank_q
);
    localparam int AW = WIDE ? 32 : 16;

    logic [AW-1:0] ptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ptr <= '0;
        else if (clr)      ptr <= '0;
        else if (shift_en) ptr <= {ptr[AW-9:0], shift_byte};
        else if (inc)      ptr <= ptr + 1'b1;
    end

    generate
        if (WIDE) begin : g_wide
            assign bank_q   = 8'h00;
            assign is_bank  = 1'b0;
            assign eff_addr = ptr;
        end else begin : g_narrow
            logic [7:0] bank_r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)       bank_r <= 8'h00;
                else if (bank_we) bank_r <= bank_din;
            end
            assign bank_q   = bank_r;
            assign is_bank  = (ptr == '0);
            assign eff_addr = {8'h00, bank_r, ptr};
        end
    endgenerate

    // R7: each read byte advances the address by one
    assert_addr_inc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && !shift_en) |=> (ptr == $past(ptr) + 1'b1));

endmodule

// File: rtl/dbgx_bridge.sv
`timescale 1ns/1ps
module dbgx_bridge
    import dbgx_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR  = 7'h59,
    parameter bit         WIDE_ADDR = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        i2c_start,
    input  logic [6:0]  i2c_dev,
    input  logic        i2c_rnw,
    input  logic        i2c_wvalid,
    input  logic [7:0]  i2c_wbyte,
    input  logic        i2c_rreq,
    input  logic        i2c_stop,
    output logic        i2c_ack,
    output logic        i2c_rvalid,
    output logic [7:0]  i2c_rbyte,
    output logic [31:0] bus_addr,
    output logic [7:0]  bus_wdata,
    output logic        bus_wr,
    output logic        bus_rd,
    input  logic [7:0]  bus_rdata,
    output logic [2:0]  chan,
    output logic        mcu_stop
);
    localparam int ABYTES = WIDE_ADDR ? 4 : 2;
    localparam int ACW    = $clog2(ABYTES);
    localparam logic [ACW-1:0] ALAST = ACW'(ABYTES - 1);

    st_t            state, nxt;
    logic           sel;
    logic [2:0]     sidx;
    logic [ACW-1:0] acnt;
    logic           en;
    logic [2:0]     chan_q;
    logic           halt_q;
    logic [7:0]     rb_q;
    logic           rv_q;

    op_t        op;
    logic [1:0] bsel;
    logic       bval;

    logic       dev_hit, wev, rev, cmd_ev;
    logic       a_clr, a_shift, a_inc, bank_we;
    logic       is_bank;
    logic [7:0] bank_q;
    logic [31:0] eff_addr;

    dbgx_cmd_dec u_dec (
        .code    (i2c_wbyte),
        .op      (op),
        .bit_sel (bsel),
        .bit_val (bval)
    );

    assign dev_hit = i2c_start && (i2c_dev == DEV_ADDR);
    assign wev     = i2c_wvalid && sel;
    assign rev     = i2c_rreq && sel;
    assign cmd_ev  = wev && (state == ST_CMD);
    assign a_clr   = cmd_ev && (op == OP_BUS);
    assign a_shift = wev && (state == ST_ADDR);
    assign a_inc   = rev && (state == ST_RDAT);
    assign bank_we = wev && (state == ST_WDAT) && en && is_bank;

    dbgx_addr_unit #(.WIDE(WIDE_ADDR)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (a_clr),
        .shift_en   (a_shift),
        .shift_byte (i2c_wbyte),
        .inc        (a_inc),
        .bank_we    (bank_we),
        .bank_din   (i2c_wbyte),
        .eff_addr   (eff_addr),
        .is_bank    (is_bank),
        .bank_q     (bank_q)
    );

    // next state
    always_comb begin
        nxt = state;
        if (i2c_start) begin
            if (dev_hit) begin
                if (state == ST_OFF || state == ST_SYNC)
                    nxt = i2c_rnw ? ST_OFF : ST_SYNC;
                else
                    nxt = i2c_rnw ? ST_RDAT : ST_CMD;
            end else if (state == ST_SYNC) begin
                nxt = ST_OFF;
            end else if (state != ST_OFF) begin
                nxt = ST_IDLE;
            end
        end else if (i2c_stop) begin
            if (state == ST_SYNC)
                nxt = (sidx == 3'(SYNC_LEN)) ? ST_IDLE : ST_OFF;
            else if (state != ST_OFF)
                nxt = ST_IDLE;
        end else if (wev) begin
            unique case (state)
                ST_CMD: begin
                    if (op == OP_BUS)       nxt = ST_ADDR;
                    else if (op == OP_EXIT) nxt = ST_OFF;
                    else                    nxt = ST_DRAIN;
                end
                ST_ADDR: if (acnt == ALAST) nxt = ST_WDAT;
                ST_OFF, ST_SYNC, ST_IDLE, ST_WDAT, ST_DRAIN, ST_RDAT: nxt = state;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    // control and data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel    <= 1'b0;
            sidx   <= '0;
            acnt   <= '0;
            en     <= 1'b0;
            chan_q <= 3'b000;
            halt_q <= 1'b0;
            rb_q   <= 8'h00;
            rv_q   <= 1'b0;
        end else begin
            if (i2c_start)     sel <= dev_hit;
            else if (i2c_stop) sel <= 1'b0;

            if (dev_hit && !i2c_rnw)
                sidx <= '0;
            else if (wev && state == ST_SYNC) begin
                if (sidx < 3'(SYNC_LEN) && i2c_wbyte == sync_byte(sidx))
                    sidx <= sidx + 1'b1;
                else
                    sidx <= 3'd7;
            end

            if (a_clr)        acnt <= '0;
            else if (a_shift) acnt <= acnt + 1'b1;

            if (cmd_ev) begin
                case (op)
                    OP_BUS_ON:           en <= 1'b1;
                    OP_BUS_OFF, OP_EXIT: en <= 1'b0;
                    OP_HALT:             halt_q <= 1'b1;
                    OP_RUN:              halt_q <= 1'b0;
                    OP_CHAN:             chan_q[bsel] <= bval;
                    default: ;
                endcase
            end

            rv_q <= rev;
            if (rev)
                rb_q <= (state == ST_RDAT && en) ? (is_bank ? bank_q : bus_rdata) : 8'h00;
        end
    end

    // outputs
    always_comb begin
        i2c_ack = 1'b0;
        if (i2c_start)
            i2c_ack = dev_hit;
        else if (wev)
            i2c_ack = !(state == ST_CMD && op == OP_EXIT);
        bus_wr     = wev && (state == ST_WDAT) && en && !is_bank;
        bus_rd     = rev && (state == ST_RDAT) && en && !is_bank;
        bus_wdata  = i2c_wbyte;
        bus_addr   = eff_addr;
        chan       = chan_q;
        mcu_stop   = halt_q;
        i2c_rvalid = rv_q;
        i2c_rbyte  = rb_q;
    end

    // R1: no bus traffic while locked
    assert_locked_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF || state == ST_SYNC) |-> !(bus_wr || bus_rd));

    // R5: strobes only while enabled
    assert_strobe_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr || bus_rd) |-> en);

    // R6: write and read never together
    assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd));

    // R7: a bus read is answered on the next cycle
    assert_rd_answer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> i2c_rvalid);

    // R3: channel moves only on a command byte
    assert_chan_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_ev |=> $stable(chan));

    // R4: halt command raises MCU stop
    assert_halt_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ev && op == OP_HALT) |=> mcu_stop);

    // R9: exit relocks and disables
    assert_exit_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ev && op == OP_EXIT) |=> (state == ST_OFF && !en));

endmodule

// File: tb/sim_dbgx_bridge.sv
`timescale 1ns/1ps
module sim_dbgx_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        i2c_start = 0, i2c_rnw = 0, i2c_wvalid = 0, i2c_rreq = 0, i2c_stop = 0;
    logic [6:0]  i2c_dev = 0;
    logic [7:0]  i2c_wbyte = 0;
    logic        i2c_ack, i2c_rvalid, bus_wr, bus_rd, mcu_stop;
    logic [7:0]  i2c_rbyte, bus_wdata, bus_rdata;
    logic [31:0] bus_addr;
    logic [2:0]  chan;

    int total = 0, bad = 0;
    bit done = 0;

    logic        last_ack, saw_wr, saw_rd, rd_ok;
    logic [31:0] wa, ra;
    logic [7:0]  wd, rd_data;

    always #2 clk = ~clk;

    assign bus_rdata = bus_addr[7:0] ^ 8'hA5;

    dbgx_bridge u0 (
        .clk(clk), .rst_n(rst_n),
        .i2c_start(i2c_start), .i2c_dev(i2c_dev), .i2c_rnw(i2c_rnw),
        .i2c_wvalid(i2c_wvalid), .i2c_wbyte(i2c_wbyte), .i2c_rreq(i2c_rreq),
        .i2c_stop(i2c_stop), .i2c_ack(i2c_ack), .i2c_rvalid(i2c_rvalid),
        .i2c_rbyte(i2c_rbyte), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .chan(chan), .mcu_stop(mcu_stop)
    );

    // {command, expected channel}
    localparam logic [15:0] CHAN_VEC [8] = '{
        {8'h81, 8'h01}, {8'h83, 8'h03}, {8'h85, 8'h07}, {8'h82, 8'h05},
        {8'h80, 8'h04}, {8'h84, 8'h00}, {8'h86, 8'h00}, {8'h85, 8'h04}
    };

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic t_start(input logic [6:0] d, input logic rnw);
        @(negedge clk); i2c_start = 1; i2c_dev = d; i2c_rnw = rnw;
        #1 last_ack = i2c_ack;
        @(negedge clk); i2c_start = 0;
    endtask

    task automatic t_stop();
        @(negedge clk); i2c_stop = 1;
        @(negedge clk); i2c_stop = 0;
    endtask

    task automatic t_wr(input logic [7:0] b);
        @(negedge clk); i2c_wvalid = 1; i2c_wbyte = b;
        #1 last_ack = i2c_ack; saw_wr = bus_wr; wa = bus_addr; wd = bus_wdata;
        @(negedge clk); i2c_wvalid = 0;
    endtask

    task automatic t_rd();
        @(negedge clk); i2c_rreq = 1;
        #1 saw_rd = bus_rd; ra = bus_addr;
        @(negedge clk); i2c_rreq = 0;
        #1 rd_ok = i2c_rvalid; rd_data = i2c_rbyte;
    endtask

    task automatic t_cmd(input logic [7:0] b);
        t_start(7'h59, 0); t_wr(b); t_stop();
    endtask

    task automatic t_sync();
        t_start(7'h59, 0);
        t_wr(8'h53); t_wr(8'h45); t_wr(8'h52); t_wr(8'h44); t_wr(8'h42);
        t_stop();
    endtask

    task automatic t_busw(input logic [7:0] hi, input logic [7:0] lo, input logic [7:0] d);
        t_start(7'h59, 0); t_wr(8'h10); t_wr(hi); t_wr(lo); t_wr(d); t_stop();
    endtask

    initial begin
        #800000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(chan == 3'd0 && mcu_stop == 0 && !bus_wr && !bus_rd && !i2c_rvalid, "R1 reset",
              {chan, mcu_stop}, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R1 commands before unlock ignored
        t_cmd(8'h83); t_cmd(8'h37); t_cmd(8'h35);
        check(chan == 3'd0 && mcu_stop == 0, "R1 locked cmd", {chan, mcu_stop}, 0);
        t_busw(8'h12, 8'h34, 8'h55);
        check(saw_wr == 0, "R1 locked bus", saw_wr, 0);

        // R2 address match
        t_start(7'h22, 0);
        check(last_ack == 0, "R2 foreign nack", last_ack, 0);
        t_stop();
        t_start(7'h59, 0);
        check(last_ack == 1, "R2 own ack", last_ack, 1);
        t_stop();

        // R1 split unlock string
        t_start(7'h59, 0); t_wr(8'h53); t_wr(8'h45); t_wr(8'h52); t_stop();
        t_start(7'h59, 0); t_wr(8'h44); t_wr(8'h42); t_stop();
        t_cmd(8'h81);
        check(chan == 3'd0, "R1 split sync", chan, 0);

        t_sync();
        // R2 foreign transfer after unlock has no effect
        t_start(7'h22, 0); t_wr(8'h85); t_stop();
        check(chan == 3'd0, "R2 foreign cmd", chan, 0);

        // R3/R10 channel table
        for (int i = 0; i < 8; i++) begin
            t_start(7'h59, 0); t_wr(CHAN_VEC[i][15:8]);
            check(last_ack == 1, "R10 cmd ack", last_ack, 1);
            t_stop();
            check(chan == CHAN_VEC[i][2:0], "R3 channel", chan, CHAN_VEC[i][2:0]);
        end

        // R4 MCU stop
        t_cmd(8'h37);
        check(mcu_stop == 1, "R4 halt", mcu_stop, 1);
        t_cmd(8'h36);
        check(mcu_stop == 0, "R4 resume", mcu_stop, 0);

        // R5 disabled bus
        t_busw(8'h12, 8'h34, 8'hAB);
        check(saw_wr == 0, "R5 no write when off", saw_wr, 0);
        t_start(7'h59, 0); t_wr(8'h10); t_wr(8'h12); t_wr(8'h34);
        t_start(7'h59, 1); t_rd(); t_stop();
        check(saw_rd == 0 && rd_ok == 1 && rd_data == 8'h00, "R5 read zero when off", rd_data, 0);

        // R6 enabled writes
        t_cmd(8'h35);
        t_start(7'h59, 0); t_wr(8'h10); t_wr(8'h12); t_wr(8'h34); t_wr(8'hAB);
        check(saw_wr && wa == 32'h0000_1234 && wd == 8'hAB, "R6 write 1", wa, 32'h1234);
        t_wr(8'hCD);
        check(saw_wr && wa == 32'h0000_1234 && wd == 8'hCD, "R6 write 2", wa, 32'h1234);
        t_stop();

        // R7 reads with increment
        t_start(7'h59, 0); t_wr(8'h10); t_wr(8'h12); t_wr(8'h34);
        t_start(7'h59, 1);
        t_rd();
        check(saw_rd && ra == 32'h0000_1234, "R7 read addr 1", ra, 32'h1234);
        check(rd_ok && rd_data == 8'h91, "R7 read data 1", rd_data, 8'h91);
        t_rd();
        check(saw_rd && ra == 32'h0000_1235, "R7 read addr 2", ra, 32'h1235);
        check(rd_ok && rd_data == 8'h90, "R7 read data 2", rd_data, 8'h90);
        t_stop();

        // R8 bank register
        t_busw(8'h00, 8'h00, 8'h10);
        check(saw_wr == 0, "R8 bank no bus", saw_wr, 0);
        t_busw(8'h1F, 8'hFE, 8'h77);
        check(saw_wr && wa == 32'h0010_1FFE, "R8 banked addr", wa, 32'h0010_1FFE);
        t_start(7'h59, 0); t_wr(8'h10); t_wr(8'h00); t_wr(8'h00);
        t_start(7'h59, 1); t_rd(); t_stop();
        check(saw_rd == 0 && rd_data == 8'h10, "R8 bank read", rd_data, 8'h10);

        // R11 trailing bytes
        t_start(7'h59, 0); t_wr(8'h83); t_wr(8'h81);
        check(last_ack == 1, "R11 trailing ack", last_ack, 1);
        t_stop();
        check(chan == 3'd6, "R11 trailing ignored", chan, 6);

        // R10 unknown command
        t_start(7'h59, 0); t_wr(8'h99);
        check(last_ack == 1, "R10 unknown ack", last_ack, 1);
        t_stop();
        check(chan == 3'd6 && mcu_stop == 0, "R10 no change", {chan, mcu_stop}, 8'h0C);
        t_busw(8'h00, 8'h42, 8'h5A);
        check(saw_wr && wa == 32'h0010_0042, "R10 enable kept", wa, 32'h0010_0042);

        // R9 exit
        t_start(7'h59, 0); t_wr(8'h45);
        check(last_ack == 0, "R9 exit nack", last_ack, 0);
        t_stop();
        t_cmd(8'h84);
        check(chan == 3'd6, "R9 locked after exit", chan, 6);
        t_sync();
        t_busw(8'h12, 8'h34, 8'h5A);
        check(saw_wr == 0, "R9 bus disabled", saw_wr, 0);
        t_cmd(8'h84);
        check(chan == 3'd2, "R9 unlock again", chan, 2);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule